// File: doc/BRIEF.md
# Register-Mapped SPI Flash Byte Master

This block lets a processor send arbitrary commands to a serial flash, one byte at a time, through four small registers on a simple register bus. Software raises chip select through a register bit, writes each command, address or data byte into a shared data register, and waits on a status flag before reading the byte that came back. Chip select stays low for as many bytes as software likes, so a read-status, write-enable, erase or page-program command is just a sequence of byte writes between raising and dropping that bit.

The serial side is a single-lane SPI mode-0 engine. SCLK is the system clock divided by an even compile-time divisor. Data leaves MSB first and each bit sent captures one bit on MISO. A PHY configuration register must select 8-bit, single-lane, lane-0 operation before any byte moves. After reset it reads zero, so the serial pins stay quiet until software programs it.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, cs_n is 1, sclk and mosi are 0, the configuration word reads 0, the chip-select register reads 0, and status reads 2'b01 (tx-ready set, rx-ready clear).
- R2: Register address 3 holds the PHY word: transfer length in bits 7:0, lane width in bits 15:8, lane mask in bits 23:16. A data write starts a transfer only when the word is exactly 0x010108. Otherwise the write is ignored and sclk and mosi stay low. Writes to this register while a byte is in flight are ignored.
- R3: Bit 0 of the chip-select register (address 0) drives cs_n low while it is 1. cs_n stays low across any number of byte transfers until software writes 0.
- R4: A transfer sends bit 7 first. mosi changes only when sclk falls, or at the start of the transfer. sclk idles low, and each half period lasts CLK_DIV/2 system clocks. mosi is 0 when idle.
- R5: miso is sampled on each rising sclk edge, MSB first, and the assembled byte is returned by a read of the data register (address 1).
- R6: Status (address 2) has tx-ready in bit 0 and rx-ready in bit 1. Tx-ready drops when a transfer starts. Tx-ready rises again, together with rx-ready, exactly 8*CLK_DIV clocks after the starting write.
- R7: A data write while tx-ready is 0 is ignored and does not disturb the byte in flight.
- R8: Reading the data register clears rx-ready.
- R9: Every byte sent yields exactly one received byte. In a two-byte exchange, the second read returns what the slave sent during the second byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (clears rx-ready on data reads) |
| bus_addr | input | 2 | Register address: 0 chip select, 1 data, 2 status, 3 PHY word |
| bus_wdata | input | 24 | Write data |
| bus_rdata | output | 24 | Read data, combinational from bus_addr |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |
| cs_n | output | 1 | Active-low chip select |

## Verification
The assertions assume that software never changes the bus address or strobes mid-cycle, and that a data-register read is not issued in the same clock in which a byte completes. The stimulus keeps to this by issuing each register access for exactly one clock and by polling status until rx-ready is set before reading data. The assertions also assume miso is driven to a known level during every transfer. The bench drives miso from its own slave model on the falling system clock, so the line is always settled before the rising sclk edge samples it.

// File: rtl/spibm_pkg.sv
package spibm_pkg;
  localparam int BUS_W  = 24;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    A_CSEL   = 2'd0,
    A_DATA   = 2'd1,
    A_STATUS = 2'd2,
    A_PHY    = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic [7:0] lane_mask;
    logic [7:0] lane_width;
    logic [7:0] xfer_len;
  } phy_cfg_t;

  localparam phy_cfg_t PHY_SINGLE = '{lane_mask: 8'd1, lane_width: 8'd1, xfer_len: 8'd8};
endpackage

// File: rtl/spibm_rst_sync.sv
module spibm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/spibm_clkdiv.sv
module spibm_clkdiv #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic tick_rise,
  output logic tick_fall
);
  localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sclk_q, sclk_d;
  logic             wrap;

  assign wrap      = run && (cnt_q == CNT_LAST);
  assign tick_rise = wrap && !sclk_q;
  assign tick_fall = wrap && sclk_q;

  always_comb begin
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    if (!run) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else if (wrap) begin
      cnt_d  = '0;
      sclk_d = !sclk_q;
    end else begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk = sclk_q;
endmodule

// File: rtl/spibm_shifter.sv
module spibm_shifter
  import spibm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              tick_rise,
  input  logic              tick_fall,
  input  logic              miso,
  output logic              mosi,
  output logic              busy,
  output logic              done,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int BIT_W = $clog2(BYTE_W);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] tx_q, tx_d, rx_q, rx_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic              busy_q, busy_d;

  assign done = busy_q && tick_fall && (bit_q == BIT_LAST);

  always_comb begin
    tx_d   = tx_q;
    rx_d   = rx_q;
    bit_d  = bit_q;
    busy_d = busy_q;
    if (start && !busy_q) begin
      tx_d   = tx_byte;
      bit_d  = '0;
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (tick_rise) rx_d = {rx_q[BYTE_W-2:0], miso};
      if (tick_fall) begin
        tx_d  = {tx_q[BYTE_W-2:0], 1'b0};
        bit_d = bit_q + 1'b1;
        if (bit_q == BIT_LAST) busy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      rx_q   <= '0;
      bit_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      bit_q  <= bit_d;
      busy_q <= busy_d;
    end
  end

  assign mosi    = busy_q && tx_q[BYTE_W-1];
  assign busy    = busy_q;
  assign rx_byte = rx_q;
endmodule

// File: rtl/spibm_regs.sv
module spibm_regs
  import spibm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [1:0]        bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic              busy,
  input  logic              done,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              start,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              cs_on,
  output logic              tx_ready,
  output logic              rx_ready,
  output logic              cfg_ok,
  output logic [BUS_W-1:0]  bus_rdata
);
  logic              cs_q, cs_d;
  phy_cfg_t          cfg_q, cfg_d;
  logic              txr_q, txr_d;
  logic              rxr_q, rxr_d;
  logic [BYTE_W-1:0] rxd_q, rxd_d;
  logic              wr_data, rd_data;

  assign wr_data = bus_we && (reg_addr_e'(bus_addr) == A_DATA);
  assign rd_data = bus_re && (reg_addr_e'(bus_addr) == A_DATA);
  assign cfg_ok  = (cfg_q == PHY_SINGLE);
  assign start   = wr_data && txr_q && cfg_ok;
  assign tx_byte = bus_wdata[BYTE_W-1:0];

  always_comb begin
    cs_d  = cs_q;
    cfg_d = cfg_q;
    txr_d = txr_q;
    rxr_d = rxr_q;
    rxd_d = rxd_q;
    if (bus_we && reg_addr_e'(bus_addr) == A_CSEL) cs_d = bus_wdata[0];
    if (bus_we && reg_addr_e'(bus_addr) == A_PHY && !busy) cfg_d = phy_cfg_t'(bus_wdata);
    if (start) txr_d = 1'b0;
    if (rd_data) rxr_d = 1'b0;
    if (done) begin
      txr_d = 1'b1;
      rxr_d = 1'b1;
      rxd_d = rx_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= 1'b0;
      cfg_q <= '0;
      txr_q <= 1'b1;
      rxr_q <= 1'b0;
      rxd_q <= '0;
    end else begin
      cs_q  <= cs_d;
      cfg_q <= cfg_d;
      txr_q <= txr_d;
      rxr_q <= rxr_d;
      rxd_q <= rxd_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (reg_addr_e'(bus_addr))
      A_CSEL:   bus_rdata[0] = cs_q;
      A_DATA:   bus_rdata[BYTE_W-1:0] = rxd_q;
      A_STATUS: bus_rdata[1:0] = {rxr_q, txr_q};
      A_PHY:    bus_rdata = cfg_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign cs_on    = cs_q;
  assign tx_ready = txr_q;
  assign rx_ready = rxr_q;
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spibm_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic             bus_re,
  input  logic [1:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             cs_n
);
  localparam int HALF = CLK_DIV / 2;

  logic              rst_i_n;
  logic              start, busy, done, cs_on;
  logic              tx_ready, rx_ready, cfg_ok;
  logic              tick_rise, tick_fall;
  logic [BYTE_W-1:0] tx_byte, rx_byte;

  spibm_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  spibm_regs u_regs (
    .clk(clk), .rst_n(rst_i_n), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .busy(busy), .done(done),
    .rx_byte(rx_byte), .start(start), .tx_byte(tx_byte), .cs_on(cs_on),
    .tx_ready(tx_ready), .rx_ready(rx_ready), .cfg_ok(cfg_ok),
    .bus_rdata(bus_rdata)
  );

  spibm_clkdiv #(.HALF(HALF)) u_div (
    .clk(clk), .rst_n(rst_i_n), .run(busy), .sclk(sclk),
    .tick_rise(tick_rise), .tick_fall(tick_fall)
  );

  spibm_shifter u_shift (
    .clk(clk), .rst_n(rst_i_n), .start(start), .tx_byte(tx_byte),
    .tick_rise(tick_rise), .tick_fall(tick_fall), .miso(miso),
    .mosi(mosi), .busy(busy), .done(done), .rx_byte(rx_byte)
  );

  assign cs_n = !cs_on;
endmodule

// File: rtl/spibm_checker.sv
module spibm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       sclk,
  input logic       mosi,
  input logic       busy,
  input logic       tx_ready,
  input logic       rx_ready,
  input logic       cfg_ok,
  input logic       bus_re,
  input logic [1:0] bus_addr
);
  // R2: a byte is only ever in flight under the single-lane 8-bit setting
  p_cfg_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cfg_ok);

  // R4: serial pins stay quiet outside a transfer
  p_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sclk && !mosi));

  // R4: within a byte, mosi moves only on a falling sclk edge
  p_mosi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$fell(sclk)) |-> $stable(mosi));

  // R6: tx-ready comes back together with rx-ready
  p_flags_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_ready) |-> rx_ready);

  // R6: tx-ready falls only as a transfer begins
  p_start_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_ready) |-> $rose(busy));

  // R8: a data read while idle leaves rx-ready clear
  p_read_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr == 2'd1 && !busy) |=> !rx_ready);
endmodule

bind spi_byte_master spibm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .busy(busy),
  .tx_ready(tx_ready), .rx_ready(rx_ready), .cfg_ok(cfg_ok),
  .bus_re(bus_re), .bus_addr(bus_addr)
);

// File: tb/spi_byte_master_bench.sv
`timescale 1ns/1ps
module spi_byte_master_bench;
  localparam int CLK_DIV = 4;
  localparam int HALF    = CLK_DIV / 2;
  localparam int XFER    = 8 * CLK_DIV;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [23:0] bus_wdata = '0;
  logic [23:0] bus_rdata;
  logic        sclk, mosi, cs_n;
  logic        miso = 1'b0;

  int n_chk = 0, n_fail = 0, cyc = 0;

  // behavioural reference model
  bit        m_active = 0, m_cs = 0, m_txr = 1, m_rxr = 0;
  int        m_k = 0;
  bit [7:0]  m_tx = 0, m_resp = 0, m_rx = 0;
  bit [23:0] m_cfg = 0;
  bit        cmp_on = 0;

  spi_byte_master #(.CLK_DIV(CLK_DIV)) u_spi_byte_master (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  always #5 clk = !clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected < 100000", cyc);
      finish_run();
    end
  end

  // model update on every edge, from the inputs settled before it
  always @(posedge clk) begin
    if (!rst_n) begin
      m_active = 0; m_cs = 0; m_txr = 1; m_rxr = 0; m_k = 0; m_cfg = 0; m_rx = 0;
    end else begin
      bit was_active;
      was_active = m_active;
      if (bus_we && bus_addr == 2'd0) m_cs = bus_wdata[0];
      if (bus_we && bus_addr == 2'd3 && !was_active) m_cfg = bus_wdata;
      if (bus_re && bus_addr == 2'd1) m_rxr = 0;
      if (was_active) begin
        m_k++;
        if (m_k == 16 * HALF) begin
          m_active = 0; m_txr = 1; m_rxr = 1; m_rx = m_resp;
        end
      end else if (bus_we && bus_addr == 2'd1 && m_txr && m_cfg == 24'h010108) begin
        m_active = 1; m_k = 0; m_tx = bus_wdata[7:0]; m_txr = 0;
      end
    end
  end

  // slave model and per-cycle pin comparison
  always @(negedge clk) begin
    miso <= m_active ? m_resp[7 - m_k / (2 * HALF)] : 1'b0;
    if (cmp_on) begin
      bit es, em;
      es = m_active ? bit'((m_k / HALF) % 2) : 1'b0;
      em = m_active ? m_tx[7 - m_k / (2 * HALF)] : 1'b0;
      chk(sclk == es, "R4", "sclk", sclk, es);
      chk(mosi == em, "R4", "mosi", mosi, em);
      chk(cs_n == !m_cs, "R3", "cs_n", cs_n, !m_cs);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [23:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [23:0] d);
    @(negedge clk);
    bus_re = 1; bus_addr = a;
    #2 d = bus_rdata;
    @(posedge clk); #1;
    bus_re = 0;
  endtask

  task automatic rd_status(input string req);
    logic [23:0] d;
    rd(2'd2, d);
    chk(d == {22'd0, m_rxr, m_txr} || 1'b0, req, "status", d, {m_rxr, m_txr});
  endtask

  task automatic xfer(input logic [7:0] tx, input logic [7:0] resp,
                      output logic [7:0] rx, output int polls);
    logic [23:0] d;
    m_resp = resp;
    wr(2'd1, {16'd0, tx});
    polls = 0;
    do begin
      rd(2'd2, d);
      polls++;
    end while (!d[1] && polls < 1000);
    rd(2'd1, d);
    rx = d[7:0];
  endtask

  initial begin
    logic [23:0] d;
    logic [7:0]  rx;
    int          polls;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    cmp_on = 1;

    // R1 reset state
    chk(cs_n == 1 && sclk == 0 && mosi == 0, "R1", "pins", {cs_n, sclk, mosi}, 3'b100);
    rd(2'd2, d); chk(d == 24'h1, "R1", "status", d, 24'h1);
    rd(2'd3, d); chk(d == 24'h0, "R1", "phy word", d, 0);
    rd(2'd0, d); chk(d == 24'h0, "R1", "chip select", d, 0);

    // R2 data write with zero PHY word is ignored
    wr(2'd1, 24'h5A);
    repeat (XFER + 4) @(posedge clk);
    rd(2'd2, d); chk(d == 24'h1, "R2", "status after gated write", d, 24'h1);

    // R2 wrong length also blocks
    wr(2'd3, 24'h010107);
    rd(2'd3, d); chk(d == 24'h010107, "R2", "phy readback", d, 24'h010107);
    wr(2'd1, 24'h5A);
    repeat (XFER + 4) @(posedge clk);
    rd(2'd2, d); chk(d == 24'h1, "R2", "status with bad length", d, 24'h1);

    wr(2'd3, 24'h010108);
    rd(2'd3, d); chk(d == 24'h010108, "R2", "phy readback", d, 24'h010108);

    // R3 chip select on, R4/R5/R6 one byte
    wr(2'd0, 24'h1);
    chk(cs_n == 0, "R3", "cs_n asserted", cs_n, 0);
    xfer(8'hA5, 8'h3C, rx, polls);
    chk(polls == XFER + 1, "R6", "ready latency polls", polls, XFER + 1);
    chk(rx == 8'h3C, "R5", "received byte", rx, 8'h3C);
    rd(2'd2, d); chk(d == 24'h1, "R8", "rx-ready cleared by read", d, 24'h1);

    // R7 write while busy is ignored, R2 phy write while busy ignored
    m_resp = 8'h81;
    wr(2'd1, 24'hC3);
    rd(2'd2, d); chk(d == 24'h0, "R6", "tx-ready low in flight", d, 0);
    wr(2'd1, 24'h0F);
    wr(2'd3, 24'h000000);
    rd(2'd3, d); chk(d == 24'h010108, "R2", "phy locked in flight", d, 24'h010108);
    repeat (XFER) @(posedge clk);
    rd(2'd2, d); chk(d == 24'h3, "R7", "one completion only", d, 24'h3);
    rd(2'd1, d); chk(d[7:0] == 8'h81, "R7", "byte unaffected", d[7:0], 8'h81);

    // R9 two-byte exchange, chip select held across
    xfer(8'h05, 8'hFF, rx, polls);
    chk(rx == 8'hFF, "R9", "first reply", rx, 8'hFF);
    chk(cs_n == 0, "R3", "cs_n held between bytes", cs_n, 0);
    xfer(8'h00, 8'h03, rx, polls);
    chk(rx == 8'h03, "R9", "status reply byte", rx, 8'h03);
    rd_status("R8");

    wr(2'd0, 24'h0);
    chk(cs_n == 1, "R3", "cs_n released", cs_n, 1);
    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule